// File: doc/BRIEF.md
# Signed Karatsuba Multiplier

This block multiplies two signed two's-complement operands and registers the full-width product. The multiplicand and multiplier widths are set independently. Each operand's sign is taken off and its magnitude is formed. Both magnitudes are then zero-extended to one shared width, which is the wider operand width rounded up to a power of two.

An unsigned core forms the product of the two magnitudes. The core splits each operand into an upper and a lower half and builds the result from three half-width products. It does this by instantiating itself on the halves until it reaches a two-bit base. The sign is put back on the core's result, and the value is captured in the product register.

A one-cycle start pulse loads the register. A one-cycle ready pulse follows on the next cycle, and the product is valid while ready is high. Apart from the product and ready registers, the whole path is combinational.

Top module: `signed_karatsuba_mul`

## Requirements
- R1: When start is high at a rising clock edge, product takes the two's-complement value of multiplicand times multiplier, sign-extended to MCAND_W+MPLR_W bits.
- R2: ready is high in the cycle after each cycle in which start was high, and only then.
- R3: When start is low at a rising clock edge, ready goes low on that edge and product keeps its previous value, whatever the operand inputs carry.
- R4: rst (active high) clears product and ready to zero at once, without waiting for a clock edge.
- R5: The most negative operand values give the exact product, including both operands at their minimum, which yields the positive value 2^(MCAND_W+MPLR_W-2).
- R6: The product is negative only when exactly one operand is negative and neither operand is zero; a zero operand gives a zero product.
- R7: The result is exact for any operand widths of 2 bits or more, whether the multiplicand is wider or narrower than the multiplier, and whether or not the wider width is a power of two.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Asynchronous reset, active high |
| start | input | 1 | One-cycle request to capture a product |
| mcand | input | MCAND_W | Signed multiplicand |
| mplr | input | MPLR_W | Signed multiplier |
| ready | output | 1 | One-cycle pulse, product valid |
| product | output | MCAND_W+MPLR_W | Signed product |

## Verification
The bench builds two instances. One has a 5-bit multiplicand and a 3-bit multiplier, and the other has a 3-bit multiplicand and a 6-bit multiplier. Both pad to an 8-bit core, so three recursion levels (8, 4 and 2 bits) and the carry corrections of the half-sums are exercised in each. With these small widths, every operand pair can be swept on each instance. The sweep covers both minimum values, zeros and all sign combinations, and it tries each width ordering. Between captures the operands are changed while start is low, to show that product holds. An asynchronous reset is also applied in the middle of a clock period.

// File: rtl/karatsuba_step.sv
module karatsuba_step #(
  parameter int W = 8
) (
  input  logic [W-1:0]   x,
  input  logic [W-1:0]   y,
  output logic [2*W-1:0] p
);
  if (W <= 2) begin : g_base
    assign p = (2*W)'(x) * (2*W)'(y);
  end else begin : g_split
    localparam int H  = W / 2;
    localparam int SW = 2 * H + 2;

    logic [H-1:0]   xh, xl, yh, yl;
    logic [H:0]     xs, ys;
    logic [2*H-1:0] ph, pl, pm;
    logic [SW-1:0]  ps, mid;

    assign xh = x[W-1:H];
    assign xl = x[H-1:0];
    assign yh = y[W-1:H];
    assign yl = y[H-1:0];
    assign xs = {1'b0, xh} + {1'b0, xl};
    assign ys = {1'b0, yh} + {1'b0, yl};

    karatsuba_step #(.W(H)) u_hi  (.x(xh),         .y(yh),         .p(ph));
    karatsuba_step #(.W(H)) u_lo  (.x(xl),         .y(yl),         .p(pl));
    karatsuba_step #(.W(H)) u_mid (.x(xs[H-1:0]),  .y(ys[H-1:0]),  .p(pm));

    // carries of the half-sums are folded in without widening the recursion
    assign ps = SW'(pm)
              + (xs[H] ? (SW'(ys[H-1:0]) << H) : '0)
              + (ys[H] ? (SW'(xs[H-1:0]) << H) : '0)
              + ((xs[H] & ys[H]) ? (SW'(1) << (2 * H)) : '0);
    assign mid = ps - SW'(ph) - SW'(pl);

    assign p = ((2*W)'(ph) << W) + ((2*W)'(mid) << H) + (2*W)'(pl);
  end
endmodule

// File: rtl/signed_karatsuba_mul.sv
module signed_karatsuba_mul #(
  parameter int MCAND_W = 16,
  parameter int MPLR_W  = 12
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start,
  input  logic [MCAND_W-1:0]         mcand,
  input  logic [MPLR_W-1:0]          mplr,
  output logic                       ready,
  output logic [MCAND_W+MPLR_W-1:0]  product
);
  localparam int PW = MCAND_W + MPLR_W;
  localparam int NW = (MCAND_W > MPLR_W) ? MCAND_W : MPLR_W;
  localparam int KW = 1 << $clog2(NW);

  logic               sa, sb, neg;
  logic [MCAND_W-1:0] ma;
  logic [MPLR_W-1:0]  mb;
  logic [KW-1:0]      ka, kb;
  logic [2*KW-1:0]    kp, sp;

  assign sa  = mcand[MCAND_W-1];
  assign sb  = mplr[MPLR_W-1];
  assign neg = sa ^ sb;
  assign ma  = sa ? (~mcand + 1'b1) : mcand;
  assign mb  = sb ? (~mplr + 1'b1) : mplr;
  assign ka  = KW'(ma);
  assign kb  = KW'(mb);

  karatsuba_step #(.W(KW)) u_core (.x(ka), .y(kb), .p(kp));

  assign sp = neg ? (~kp + 1'b1) : kp;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      ready   <= 1'b0;
      product <= '0;
    end else begin
      ready <= start;
      if (start) product <= sp[PW-1:0];
    end
  end
endmodule

// File: rtl/signed_karatsuba_mul_chk.sv
module signed_karatsuba_mul_chk #(
  parameter int MCAND_W = 16,
  parameter int MPLR_W  = 12
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      start,
  input logic [MCAND_W-1:0]        mcand,
  input logic [MPLR_W-1:0]         mplr,
  input logic                      ready,
  input logic [MCAND_W+MPLR_W-1:0] product
);
  // R1
  product_value_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> $signed(product) == $signed($past(mcand)) * $signed($past(mplr)));

  // R2
  ready_after_start_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> ready);

  // R3
  ready_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !start |=> !ready);

  // R3
  product_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !start |=> $stable(product));

  // R4
  always @(negedge clk) begin
    if (rst) reset_clear_chk: assert (!ready && product == '0);
  end
endmodule

bind signed_karatsuba_mul signed_karatsuba_mul_chk #(.MCAND_W(MCAND_W), .MPLR_W(MPLR_W)) u_chk (
  .clk(clk), .rst(rst), .start(start), .mcand(mcand), .mplr(mplr),
  .ready(ready), .product(product)
);

// File: tb/test_signed_karatsuba_mul.sv
module test_signed_karatsuba_mul;
  localparam time CLK_PERIOD = 10ns;
  localparam int AW1 = 5, BW1 = 3;
  localparam int AW2 = 3, BW2 = 6;

  logic clk = 1'b0, rst = 1'b1;
  logic st1 = 1'b0, st2 = 1'b0;
  logic [AW1-1:0] a1 = '0;
  logic [BW1-1:0] b1 = '0;
  logic [AW2-1:0] a2 = '0;
  logic [BW2-1:0] b2 = '0;
  logic rdy1, rdy2;
  logic [AW1+BW1-1:0] p1;
  logic [AW2+BW2-1:0] p2;

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  signed_karatsuba_mul #(.MCAND_W(AW1), .MPLR_W(BW1)) i_signed_karatsuba_mul (
    .clk(clk), .rst(rst), .start(st1), .mcand(a1), .mplr(b1), .ready(rdy1), .product(p1));

  signed_karatsuba_mul #(.MCAND_W(AW2), .MPLR_W(BW2)) i_signed_karatsuba_mul_b (
    .clk(clk), .rst(rst), .start(st2), .mcand(a2), .mplr(b2), .ready(rdy2), .product(p2));

  task automatic check(input string req, input longint act, input longint exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic string tag(input longint ea, input longint eb);
    longint lo1 = -(longint'(1) << 4);
    if (ea == 0 || eb == 0) return "R6";
    if (ea < -3 || eb < -3) return "R5";
    return "R1";
  endfunction

  task automatic sweep1();
    for (int i = 0; i < (1 << AW1); i++) begin
      for (int j = 0; j < (1 << BW1); j++) begin
        longint ea, eb, held;
        @(negedge clk);
        a1 = AW1'(i); b1 = BW1'(j); st1 = 1'b1;
        ea = longint'($signed(a1)); eb = longint'($signed(b1));
        @(negedge clk);
        st1 = 1'b0; a1 = ~a1; b1 = b1 + 1'b1;
        check("R2", rdy1, 1);
        check(tag(ea, eb), longint'($signed(p1)), ea * eb);
        check("R7", longint'($signed(p1)), ea * eb);
        held = longint'($signed(p1));
        @(negedge clk);
        check("R3", rdy1, 0);
        check("R3", longint'($signed(p1)), held);
      end
    end
  endtask

  task automatic sweep2();
    for (int i = 0; i < (1 << AW2); i++) begin
      for (int j = 0; j < (1 << BW2); j++) begin
        longint ea, eb;
        @(negedge clk);
        a2 = AW2'(i); b2 = BW2'(j); st2 = 1'b1;
        ea = longint'($signed(a2)); eb = longint'($signed(b2));
        @(negedge clk);
        st2 = 1'b0;
        check("R2", rdy2, 1);
        check(tag(ea, eb), longint'($signed(p2)), ea * eb);
        check("R7", longint'($signed(p2)), ea * eb);
      end
    end
    @(negedge clk);
    check("R3", rdy2, 0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    check("R4", rdy1, 0);
    check("R4", longint'(p1), 0);
    check("R4", longint'(p2), 0);
    rst = 1'b0;
    @(negedge clk);
    // R5: both operands at minimum
    a1 = 5'b10000; b1 = 3'b100; st1 = 1'b1;
    @(negedge clk);
    st1 = 1'b0;
    check("R5", longint'($signed(p1)), 64);
    // R6: sign of result with negative times positive
    a1 = 5'b11111; b1 = 3'b011; st1 = 1'b1;
    @(negedge clk);
    st1 = 1'b0;
    check("R6", longint'($signed(p1)), -3);
    sweep1();
    sweep2();
    // R4: asynchronous clear mid-period
    @(negedge clk);
    a1 = 5'b01111; b1 = 3'b011; st1 = 1'b1;
    @(negedge clk);
    st1 = 1'b0;
    check("R1", longint'($signed(p1)), 45);
    #(CLK_PERIOD/4);
    rst = 1'b1;
    #1;
    check("R4", longint'(p1), 0);
    check("R4", rdy1, 0);
    @(negedge clk);
    rst = 1'b0;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule